// File: doc/BRIEF.md
# Self-Calibrating Zero-Crossing Speed Detector

This block is the digital heart of a two-wire wheel-speed sensor. Each clock it receives one signed sample of the differential field signal. It counts qualified swings of that signal and learns the signal's lowest and highest values. From their midpoint it derives the code for the offset-cancellation DAC. Once calibrated, it drives a single speed bit. The bit goes high and low as the offset-corrected signal passes through zero.

After reset the block opens a short blind window in which samples are ignored. It then stays uncalibrated, with the speed bit forced low, until a set number of qualified edges has been seen. In the running phase the DAC code follows the latest pair of peaks. It moves only when the new midpoint is at least two codes away from the current code, so the code never dithers by one LSB. The output switches with a little hysteresis, and only when the signal has made a large enough excursion on the opposite side. Small signals therefore never reach the output. If the signal stays still for the standstill interval, the block goes back to the blind window and recalibrates. The two intervals are derived from a clock-frequency parameter.

Top module: `speed_zc_core`

## Requirements
- R1: An active-low asynchronous reset sets `speed_o` to 0 and `dac_o` to 0, and starts the blind calibration window in the uncalibrated phase.
- R2: For WIN_CYC clock cycles after reset or after a standstill timeout, the sample input is ignored. The value present in the last cycle of the window becomes the starting reference, minimum and maximum.
- R3: A qualified edge occurs when the sample has moved strictly more than EDGE_AMP codes away from the most recent extreme (the running maximum while rising, the running minimum while falling). Each qualified edge reverses the tracked direction.
- R4: In the uncalibrated phase, the block becomes calibrated on the EDGE_N-th qualified edge. At that edge `dac_o` loads floor((min+max)/2) of all samples seen since the window closed, including the current sample.
- R5: While uncalibrated, `speed_o` stays 0 whatever the input does.
- R6: When calibrated, with c = sample − `dac_o`, the output rises when c > HYST and falls when c < −HYST, subject to R7.
- R7: A toggle is allowed only if, since the previous toggle or since calibration, c has reached ≤ −LIM_PP/2 (before a rise) or ≥ +LIM_PP/2 (before a fall). Swings smaller than LIM_PP peak-to-peak around the midpoint never switch the output.
- R8: When calibrated, each qualified edge stores the extreme it ends as the new peak (maximum on a falling edge, minimum on a rising edge). `dac_o` takes floor((max+min)/2) of the stored peaks only when that value differs from the current code by 2 or more.
- R9: If no qualified edge occurs for STILL_CYC cycles outside the window, `speed_o` drops to 0, the edge count clears and the window of R2 restarts. `dac_o` keeps its value until the next calibration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; one sample per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sample_i | input | W | Signed differential-signal sample from the ADC |
| speed_o | output | 1 | Speed bit driving the current output stage |
| dac_o | output | W | Signed offset-cancellation DAC code |

## Verification
The main function is driven with triangle waves of known peaks. A wave centred on the initial offset gives a first midpoint. A wave whose peaks step upward then separates peak-pair tracking from a full min/max, and placing each toggle point between the hysteresis thresholds tells the two apart. A peak pair that shifts the midpoint by exactly one code, and then by two, separates the low-jitter rule from plain tracking. A small oscillation around the midpoint and a long constant level show the amplitude gate and the standstill recalibration. A large glitch inside the blind window would move the first DAC code if the window were not honoured.

// File: rtl/speed_zc_core.sv
module speed_zc_core #(
  parameter int W        = 12,
  parameter int EDGE_N   = 3,
  parameter int EDGE_AMP = 40,
  parameter int LIM_PP   = 32,
  parameter int HYST     = 3,
  parameter int CLK_KHZ  = 10,
  parameter int STILL_MS = 700,
  parameter int WIN_US   = 300
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic signed [W-1:0] sample_i,
  output logic                speed_o,
  output logic signed [W-1:0] dac_o
);
  localparam int STILL_CYC = CLK_KHZ * STILL_MS;
  localparam int WIN_RAW   = (CLK_KHZ * WIN_US + 999) / 1000;
  localparam int WIN_CYC   = (WIN_RAW < 1) ? 1 : WIN_RAW;
  localparam int TW        = $clog2(STILL_CYC + WIN_CYC + 1);
  localparam int EW        = $clog2(EDGE_N + 1);
  localparam logic [TW-1:0] WIN_LAST   = TW'(WIN_CYC - 1);
  localparam logic [TW-1:0] STILL_LAST = TW'(STILL_CYC - 1);
  localparam logic [EW-1:0] EDGE_LAST  = EW'(EDGE_N - 1);
  localparam logic signed [W:0] K_AMP   = (W+1)'(EDGE_AMP);
  localparam logic signed [W:0] K_HYST  = (W+1)'(HYST);
  localparam logic signed [W:0] K_NHYST = (W+1)'(-HYST);
  localparam logic signed [W:0] K_LIM   = (W+1)'(LIM_PP / 2);
  localparam logic signed [W:0] K_NLIM  = (W+1)'(-(LIM_PP / 2));
  localparam logic signed [W:0] K_TWO   = (W+1)'(2);
  localparam logic signed [W:0] K_NTWO  = (W+1)'(-2);

  typedef enum logic [1:0] {S_WIN = 2'd0, S_ACQ = 2'd1, S_RUN = 2'd2} st_t;
  typedef enum logic [1:0] {D_NONE, D_UP, D_DN} dir_t;

  st_t                st;
  dir_t               dir, dir_n;
  logic [TW-1:0]      tc;
  logic [EW-1:0]      ecnt;
  logic signed [W-1:0] r, r_n, mn, mx, mn_n, mx_n, pmin, pmax, acq_mid, cand;
  logic               edg, ris, arm;
  logic signed [W:0]  x, up_d, dn_d, c, dstep, acq_sum, run_sum;

  assign x       = {sample_i[W-1], sample_i};
  assign up_d    = x - {r[W-1], r};
  assign dn_d    = {r[W-1], r} - x;
  assign mn_n    = (sample_i < mn) ? sample_i : mn;
  assign mx_n    = (sample_i > mx) ? sample_i : mx;
  assign acq_sum = {mn_n[W-1], mn_n} + {mx_n[W-1], mx_n};
  assign acq_mid = acq_sum[W:1];
  assign run_sum = ris ? ({pmax[W-1], pmax} + {r[W-1], r})
                       : ({r[W-1], r} + {pmin[W-1], pmin});
  assign cand    = run_sum[W:1];
  assign dstep   = {cand[W-1], cand} - {dac_o[W-1], dac_o};
  assign c       = x - {dac_o[W-1], dac_o};

  always_comb begin
    edg   = 1'b0;
    ris   = 1'b0;
    r_n   = r;
    dir_n = dir;
    case (dir)
      D_UP: begin
        if (sample_i > r) r_n = sample_i;
        else if (dn_d > K_AMP) begin edg = 1'b1; dir_n = D_DN; r_n = sample_i; end
      end
      D_DN: begin
        if (sample_i < r) r_n = sample_i;
        else if (up_d > K_AMP) begin edg = 1'b1; ris = 1'b1; dir_n = D_UP; r_n = sample_i; end
      end
      default: begin
        if (up_d > K_AMP) begin edg = 1'b1; ris = 1'b1; dir_n = D_UP; r_n = sample_i; end
        else if (dn_d > K_AMP) begin edg = 1'b1; dir_n = D_DN; r_n = sample_i; end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= S_WIN; dir <= D_NONE; tc <= '0; ecnt <= '0;
      r <= '0; mn <= '0; mx <= '0; pmin <= '0; pmax <= '0;
      dac_o <= '0; speed_o <= 1'b0; arm <= 1'b0;
    end else if (st == S_WIN) begin
      speed_o <= 1'b0;
      arm     <= 1'b0;
      ecnt    <= '0;
      if (tc == WIN_LAST) begin
        st <= S_ACQ; tc <= '0; dir <= D_NONE;
        r <= sample_i; mn <= sample_i; mx <= sample_i;
      end else tc <= tc + 1'b1;
    end else begin
      r   <= r_n;
      dir <= dir_n;
      tc  <= edg ? '0 : tc + 1'b1;
      if (st == S_ACQ) begin
        mn <= mn_n;
        mx <= mx_n;
        if (edg) begin
          if (ecnt == EDGE_LAST) begin
            st <= S_RUN; dac_o <= acq_mid; pmin <= mn_n; pmax <= mx_n; ecnt <= '0;
          end else ecnt <= ecnt + 1'b1;
        end
      end else begin
        if (edg) begin
          if (ris) pmin <= r;
          else     pmax <= r;
          if (dstep >= K_TWO || dstep <= K_NTWO) dac_o <= cand;
        end
        if (speed_o) begin
          if (arm && c < K_NHYST) begin speed_o <= 1'b0; arm <= 1'b0; end
          else if (c >= K_LIM) arm <= 1'b1;
        end else begin
          if (arm && c > K_HYST) begin speed_o <= 1'b1; arm <= 1'b0; end
          else if (c <= K_NLIM) arm <= 1'b1;
        end
      end
      if (!edg && tc == STILL_LAST) begin
        st <= S_WIN; tc <= '0; speed_o <= 1'b0; arm <= 1'b0; ecnt <= '0;
      end
    end
  end
endmodule

// File: rtl/speed_zc_chk.sv
module speed_zc_chk #(
  parameter int W  = 12,
  parameter int EW = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          st,
  input logic                spd,
  input logic signed [W-1:0] dac,
  input logic                arm,
  input logic [EW-1:0]       ecnt
);
  logic signed [W-1:0] dac_q;
  logic [1:0]          st_q;
  logic                spd_q, arm_q, q_ok;
  logic signed [W:0]   dstep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_q <= '0; st_q <= 2'd0; spd_q <= 1'b0; arm_q <= 1'b0; q_ok <= 1'b0;
    end else begin
      dac_q <= dac; st_q <= st; spd_q <= spd; arm_q <= arm; q_ok <= 1'b1;
    end
  end

  assign dstep = {dac[W-1], dac} - {dac_q[W-1], dac_q};

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      rst_state_chk: assert (dac == '0 && !spd && st == 2'd0);
    end
  end

  // R2
  win_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0) |-> (ecnt == '0 && !spd));

  // R5
  uncal_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 2'd2) |-> !spd);

  // R7
  armed_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_ok && st == 2'd2 && st_q == 2'd2 && spd != spd_q) |-> arm_q);

  // R8
  dac_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_ok && st == 2'd2 && st_q == 2'd2 && dac != dac_q) |-> (dstep >= 2 || dstep <= -2));
endmodule

bind speed_zc_core speed_zc_chk #(.W(W), .EW(EW)) u_chk (
  .clk(clk_i), .rst_n(rst_ni), .st(st), .spd(speed_o),
  .dac(dac_o), .arm(arm), .ecnt(ecnt)
);

// File: tb/test_speed_zc_core.sv
module test_speed_zc_core;
  localparam int W = 12;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic signed [W-1:0] smp = '0;
  logic                spd;
  logic signed [W-1:0] dac;

  always #2 clk = ~clk;

  speed_zc_core i_speed_zc_core (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(smp), .speed_o(spd), .dac_o(dac)
  );

  int    n_cmp = 0, n_bad = 0;
  int    q_kind[$];
  int    q_val[$];
  string q_tag[$];
  bit    timed_out = 0;

  task automatic expect_ev(input int kind, input int val, input string tag);
    q_kind.push_back(kind); q_val.push_back(val); q_tag.push_back(tag);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic got(input int kind, input int val);
    int k, v; string t;
    if (q_kind.size() == 0) begin
      n_cmp++; n_bad++;
      $display("FAIL unexpected %s event: actual %0d expected none (R5/R7)",
               kind ? "dac" : "speed", val);
    end else begin
      k = q_kind.pop_front(); v = q_val.pop_front(); t = q_tag.pop_front();
      n_cmp++;
      if (k != kind || v != val) begin
        n_bad++;
        $display("FAIL %s: actual %s=%0d expected %s=%0d", t,
                 kind ? "dac" : "speed", val, k ? "dac" : "speed", v);
      end
    end
  endtask

  initial begin
    logic pspd;
    int   pdac;
    pspd = 1'b0; pdac = 0;
    forever begin
      @(posedge clk); #1;
      if (int'(dac) != pdac) begin pdac = int'(dac); got(1, pdac); end
      if (spd !== pspd)      begin pspd = spd; got(0, int'(pspd)); end
    end
  end

  task automatic ramp(input int a, input int b, input int st);
    int v;
    v = a;
    forever begin
      @(negedge clk) smp = W'(v);
      if (v == b) break;
      if (a < b) v = (v + st > b) ? b : v + st;
      else       v = (v - st < b) ? b : v - st;
    end
  endtask

  task automatic hold(input int v, input int n);
    for (int i = 0; i < n; i++) @(negedge clk) smp = W'(v);
  endtask

  task automatic run_all;
    repeat (3) @(negedge clk);
    chk("R1 speed in reset", int'(spd), 0);
    chk("R1 dac in reset", int'(dac), 0);
    @(negedge clk) begin rst_n = 1'b1; smp = -12'sd300; end
    @(negedge clk) smp = 12'sd100;
    ramp(100, 180, 4);
    ramp(180, 20, 4);
    chk("R5 speed low before calibration", int'(spd), 0);
    expect_ev(1, 100, "R2/R4 first midpoint");
    expect_ev(0, 1, "R6 rise");
    ramp(20, 180, 4);
    expect_ev(0, 0, "R6 fall");
    ramp(180, 20, 4);
    expect_ev(0, 1, "R6 rise");
    ramp(20, 220, 4);
    expect_ev(1, 120, "R3/R8 peak max update");
    expect_ev(0, 0, "R6 fall after dac 120");
    ramp(220, 60, 4);
    expect_ev(1, 140, "R8 peak min update");
    expect_ev(0, 1, "R6 rise after dac 140");
    ramp(60, 220, 4);
    expect_ev(0, 0, "R6 fall");
    ramp(220, 60, 4);
    expect_ev(0, 1, "R6 rise");
    ramp(60, 222, 4);
    expect_ev(0, 0, "R8 one-code shift held, R6 fall");
    ramp(222, 62, 4);
    chk("R8 dac held on one-code shift", int'(dac), 140);
    expect_ev(1, 142, "R8 two-code shift applied");
    expect_ev(0, 1, "R6 rise after dac 142");
    ramp(62, 222, 4);
    expect_ev(0, 0, "R6 fall");
    ramp(222, 132, 4);
    for (int k = 0; k < 3; k++) begin
      ramp(132, 152, 4);
      ramp(152, 132, 4);
    end
    chk("R7 small swing no toggle", int'(spd), 0);
    chk("R7 small swing dac", int'(dac), 142);
    ramp(132, 120, 4);
    expect_ev(0, 1, "R6/R7 rise after full excursion");
    ramp(120, 158, 4);
    chk("R6 speed high", int'(spd), 1);
    expect_ev(0, 0, "R9 standstill drops output");
    hold(158, 7100);
    chk("R9 dac held after standstill", int'(dac), 142);
    ramp(158, 260, 4);
    ramp(260, 100, 4);
    chk("R5 speed low during recalibration", int'(spd), 0);
    expect_ev(1, 180, "R4/R9 recalibrated midpoint");
    expect_ev(0, 1, "R5/R6 output re-enabled");
    ramp(100, 260, 4);
    expect_ev(1, 0, "R1 reset clears dac");
    expect_ev(0, 0, "R1 reset clears speed");
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 speed after reset", int'(spd), 0);
    chk("R1 dac after reset", int'(dac), 0);
    chk("all expected events seen", q_kind.size(), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule